// File: doc/BRIEF.md
# Decode-Stage Interlock Stall Generator

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may proceed. The pipeline has no forwarding paths, so an instruction has to wait until every older instruction that writes one of its source registers has left writeback. The block decodes the opcode class of the decode-stage instruction into two source read enables and a destination write enable. It keeps a small record of the destination and write enable of the instructions now in execute, memory and writeback, and raises `stall` whenever a read source matches a pending write.

While `stall` is high, the surrounding pipeline holds its program counter and decode instruction register. The block loads a bubble (write enable off) into its execute slot. The instructions already in execute and memory keep moving one stage per cycle. If the instruction in execute is a conditional branch that is taken, the instruction in decode is on the wrong path. In that case the stall is withheld, `branch_kill` is raised, and the decode-stage instruction enters execute as a bubble instead of as itself. The register file, ALU, memories and next-PC selection live outside the block.

Top module: `interlock_unit`

## Requirements
- R1: While reset is active and in the cycle after it is released, `stall` and `branch_kill` are low and `ex_wen`, `mem_wen` and `wb_wen` are all low.
- R2: `id_op` codes are: 0 nop, 1 register-register ALU, 2 ALU-immediate, 3 load, 4 store, 5 branch-if-zero, 6 branch-if-nonzero, 7 jump, 8 jump-and-link, 9 jump-register, 10 jump-and-link-register. Codes 11 to 15 neither read nor write a register.
- R3: The destination is `id_rd` for code 1, `id_rt` for codes 2 and 3, and the all-ones register (31) for codes 8 and 10.
- R4: The write enable is on for codes 1, 2 and 3 only when their destination is not register 0. It is always on for codes 8 and 10 and off for every other code. A write to register 0 never causes a stall.
- R5: The first source `id_rs` is read by codes 1, 2, 3, 4, 5, 6, 9 and 10.
- R6: The second source `id_rt` is read only by codes 1 and 4.
- R7: `stall` is high when a read source equals the destination of an execute, memory or writeback slot whose write enable is set. The only exception is the case covered by R8.
- R8: When the execute slot holds code 5 with `ex_src_zero` high, or code 6 with `ex_src_zero` low, `branch_kill` is high and `stall` is low. On the next edge the execute slot becomes a bubble.
- R9: On each edge, a stall loads a bubble into the execute slot. Otherwise the execute slot takes the decoded destination and write enable. Memory takes the old execute contents and writeback takes the old memory contents.
- R10: A reader issued directly after a writer of its source stalls three cycles. With one, two or three independent instructions in between, it stalls two, one or zero cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_op | input | 4 | Opcode class of the decode-stage instruction |
| id_rs | input | REG_W | First source register field |
| id_rt | input | REG_W | Second source / immediate-form destination field |
| id_rd | input | REG_W | Register-form destination field |
| ex_src_zero | input | 1 | Source operand of the execute-stage instruction is zero |
| stall | output | 1 | Hold fetch and decode, insert a bubble |
| branch_kill | output | 1 | Taken branch in execute; decode instruction is invalid |
| ex_wen | output | 1 | Write enable of the execute slot |
| ex_dst | output | REG_W | Destination of the execute slot |
| mem_wen | output | 1 | Write enable of the memory slot |
| mem_dst | output | REG_W | Destination of the memory slot |
| wb_wen | output | 1 | Write enable of the writeback slot |
| wb_dst | output | REG_W | Destination of the writeback slot |

## Verification
Every ordered pair of the sixteen opcode codes is issued back to back. In each pair the reader's fields point at the writer's destination, and the run is repeated with that destination set to register 0 and to a nonzero register. This separates the per-class read enables, the per-class destination choice and the register-0 rule, because each one changes the expected stall count from three to zero. Separate sequences put one to three independent instructions between writer and reader to tell the execute, memory and writeback comparisons apart. A jump-and-link followed by a jump-register checks the link destination. A writer, a branch and a reader are then run with the branch taken and not taken, which shows the kill overriding a pending memory-stage match.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ALU   = 4'd1,
        OP_ALUI  = 4'd2,
        OP_LOAD  = 4'd3,
        OP_STORE = 4'd4,
        OP_BEQZ  = 4'd5,
        OP_BNEZ  = 4'd6,
        OP_J     = 4'd7,
        OP_JAL   = 4'd8,
        OP_JR    = 4'd9,
        OP_JALR  = 4'd10
    } op_e;

endpackage

// File: rtl/ilk_decode.sv
module ilk_decode #(
    parameter int unsigned REG_W = 5
) (
    input  ilk_pkg::op_e       op_i,
    input  logic [REG_W-1:0]   rt_i,
    input  logic [REG_W-1:0]   rd_i,
    output logic               re_a_o,
    output logic               re_b_o,
    output logic               wen_o,
    output logic [REG_W-1:0]   dst_o
);
    import ilk_pkg::*;

    localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

    logic [REG_W-1:0] dst_sel;
    logic             may_write;
    logic             always_write;

    always_comb begin
        re_a_o       = 1'b0;
        re_b_o       = 1'b0;
        may_write    = 1'b0;
        always_write = 1'b0;
        dst_sel      = '0;
        unique case (op_i)
            OP_ALU: begin
                re_a_o    = 1'b1;
                re_b_o    = 1'b1;
                may_write = 1'b1;
                dst_sel   = rd_i;
            end
            OP_ALUI, OP_LOAD: begin
                re_a_o    = 1'b1;
                may_write = 1'b1;
                dst_sel   = rt_i;
            end
            OP_STORE: begin
                re_a_o = 1'b1;
                re_b_o = 1'b1;
            end
            OP_BEQZ, OP_BNEZ, OP_JR: begin
                re_a_o = 1'b1;
            end
            OP_JAL: begin
                always_write = 1'b1;
                dst_sel      = LINK_REG;
            end
            OP_JALR: begin
                re_a_o       = 1'b1;
                always_write = 1'b1;
                dst_sel      = LINK_REG;
            end
            default: begin
                re_a_o = 1'b0;
            end
        endcase
        wen_o = always_write | (may_write & (dst_sel != '0));
        dst_o = wen_o ? dst_sel : '0;
    end

endmodule

// File: rtl/ilk_match.sv
module ilk_match #(
    parameter int unsigned REG_W = 5,
    parameter int unsigned NSTG  = 3
) (
    input  logic [REG_W-1:0]            src_i,
    input  logic                        re_i,
    input  logic [NSTG-1:0]             stg_wen_i,
    input  logic [NSTG-1:0][REG_W-1:0]  stg_dst_i,
    output logic                        hit_o
);
    logic [NSTG-1:0] per_stage;

    for (genvar g = 0; g < NSTG; g++) begin : g_cmp
        assign per_stage[g] = stg_wen_i[g] & (stg_dst_i[g] == src_i);
    end

    assign hit_o = re_i & (|per_stage);

endmodule

// File: rtl/ilk_track.sv
module ilk_track #(
    parameter int unsigned REG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bubble_i,
    input  logic               wen_i,
    input  logic [REG_W-1:0]   dst_i,
    input  ilk_pkg::op_e       op_i,
    output logic               ex_wen_o,
    output logic [REG_W-1:0]   ex_dst_o,
    output ilk_pkg::op_e       ex_op_o,
    output logic               mem_wen_o,
    output logic [REG_W-1:0]   mem_dst_o,
    output logic               wb_wen_o,
    output logic [REG_W-1:0]   wb_dst_o
);
    import ilk_pkg::*;

    typedef struct packed {
        logic             wen;
        logic [REG_W-1:0] dst;
        op_e              op;
    } slot_t;

    typedef struct packed {
        slot_t ex;
        slot_t mem;
        slot_t wb;
    } pipe_t;

    localparam slot_t EMPTY = '{wen: 1'b0, dst: '0, op: OP_NOP};

    pipe_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.wb  = st_q.mem;
        st_d.mem = st_q.ex;
        if (bubble_i) begin
            st_d.ex = EMPTY;
        end else begin
            st_d.ex.wen = wen_i;
            st_d.ex.dst = dst_i;
            st_d.ex.op  = op_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ex: EMPTY, mem: EMPTY, wb: EMPTY};
        end else begin
            st_q <= st_d;
        end
    end

    assign ex_wen_o  = st_q.ex.wen;
    assign ex_dst_o  = st_q.ex.dst;
    assign ex_op_o   = st_q.ex.op;
    assign mem_wen_o = st_q.mem.wen;
    assign mem_dst_o = st_q.mem.dst;
    assign wb_wen_o  = st_q.wb.wen;
    assign wb_dst_o  = st_q.wb.dst;

    // R9: a bubble request leaves the execute slot without a write
    p_bubble_enters_ex_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_i |=> !ex_wen_o);

    // R9: execute contents move on to memory, memory to writeback
    p_slots_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mem_wen_o == $past(ex_wen_o)) && (mem_dst_o == $past(ex_dst_o))
              && (wb_wen_o == $past(mem_wen_o)) && (wb_dst_o == $past(mem_dst_o)));

    // R4: no slot ever carries a live write to register 0
    p_no_zero_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wen_o -> ex_dst_o != '0) && (wb_wen_o -> wb_dst_o != '0));

endmodule

// File: rtl/interlock_unit.sv
module interlock_unit #(
    parameter int unsigned REG_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         id_op,
    input  logic [REG_W-1:0]   id_rs,
    input  logic [REG_W-1:0]   id_rt,
    input  logic [REG_W-1:0]   id_rd,
    input  logic               ex_src_zero,
    output logic               stall,
    output logic               branch_kill,
    output logic               ex_wen,
    output logic [REG_W-1:0]   ex_dst,
    output logic               mem_wen,
    output logic [REG_W-1:0]   mem_dst,
    output logic               wb_wen,
    output logic [REG_W-1:0]   wb_dst
);
    import ilk_pkg::*;

    localparam int unsigned     NSTG     = 3;
    localparam logic [REG_W-1:0] LINK_REG = {REG_W{1'b1}};

    op_e              dec_op;
    op_e              ex_op;
    logic             dec_re_a, dec_re_b, dec_wen;
    logic [REG_W-1:0] dec_dst;
    logic             hit_a, hit_b;
    logic             taken;
    logic             hazard;

    logic [NSTG-1:0]            stg_wen;
    logic [NSTG-1:0][REG_W-1:0] stg_dst;

    assign dec_op = op_e'(id_op);

    ilk_decode #(.REG_W(REG_W)) i_decode (
        .op_i   (dec_op),
        .rt_i   (id_rt),
        .rd_i   (id_rd),
        .re_a_o (dec_re_a),
        .re_b_o (dec_re_b),
        .wen_o  (dec_wen),
        .dst_o  (dec_dst)
    );

    assign stg_wen = {wb_wen, mem_wen, ex_wen};
    assign stg_dst = {wb_dst, mem_dst, ex_dst};

    ilk_match #(.REG_W(REG_W), .NSTG(NSTG)) i_match_a (
        .src_i     (id_rs),
        .re_i      (dec_re_a),
        .stg_wen_i (stg_wen),
        .stg_dst_i (stg_dst),
        .hit_o     (hit_a)
    );

    ilk_match #(.REG_W(REG_W), .NSTG(NSTG)) i_match_b (
        .src_i     (id_rt),
        .re_i      (dec_re_b),
        .stg_wen_i (stg_wen),
        .stg_dst_i (stg_dst),
        .hit_o     (hit_b)
    );

    always_comb begin
        taken  = ((ex_op == OP_BEQZ) &  ex_src_zero)
               | ((ex_op == OP_BNEZ) & ~ex_src_zero);
        hazard = hit_a | hit_b;
    end

    assign branch_kill = taken;
    assign stall       = hazard & ~taken;

    ilk_track #(.REG_W(REG_W)) i_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bubble_i  (stall | taken),
        .wen_i     (dec_wen),
        .dst_i     (dec_dst),
        .op_i      (dec_op),
        .ex_wen_o  (ex_wen),
        .ex_dst_o  (ex_dst),
        .ex_op_o   (ex_op),
        .mem_wen_o (mem_wen),
        .mem_dst_o (mem_dst),
        .wb_wen_o  (wb_wen),
        .wb_dst_o  (wb_dst)
    );

    // R8: a taken branch in execute never coexists with a stall
    p_kill_beats_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_kill |-> !stall);

    // R8: the instruction in decode during a kill becomes a bubble
    p_kill_leaves_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        branch_kill |=> !ex_wen);

    // R7: a stall always has some pending writer behind it
    p_stall_has_writer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_wen || mem_wen || wb_wen));

    // R3: link instructions in execute target the all-ones register
    p_link_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_wen && (ex_op == OP_JAL || ex_op == OP_JALR)) |-> (ex_dst == LINK_REG));

    // R1: outputs are quiet in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!ex_wen && !mem_wen && !wb_wen && !branch_kill));

endmodule

// File: tb/test_interlock_unit.sv
`timescale 1ns/1ps
module test_interlock_unit;

    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [3:0]       id_op;
    logic [REG_W-1:0] id_rs, id_rt, id_rd;
    logic             ex_src_zero;
    logic             stall, branch_kill;
    logic             ex_wen, mem_wen, wb_wen;
    logic [REG_W-1:0] ex_dst, mem_dst, wb_dst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // shadow of the three slots, built from the requirements
    logic       sh_wen [3];
    logic [4:0] sh_dst [3];
    int         sh_eop;

    always #10 clk = ~clk;

    interlock_unit #(.REG_W(REG_W)) i_interlock_unit (
        .clk(clk), .rst_n(rst_n), .id_op(id_op), .id_rs(id_rs), .id_rt(id_rt),
        .id_rd(id_rd), .ex_src_zero(ex_src_zero), .stall(stall),
        .branch_kill(branch_kill), .ex_wen(ex_wen), .ex_dst(ex_dst),
        .mem_wen(mem_wen), .mem_dst(mem_dst), .wb_wen(wb_wen), .wb_dst(wb_dst)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit f_re1(input int op);
        return (op >= 1 && op <= 6) || op == 9 || op == 10;       // R5
    endfunction
    function automatic bit f_re2(input int op);
        return op == 1 || op == 4;                                // R6
    endfunction
    function automatic int f_dst(input int op, input int rt, input int rd);
        if (op == 1) return rd;                                   // R3
        if (op == 2 || op == 3) return rt;
        if (op == 8 || op == 10) return 31;
        return 0;
    endfunction
    function automatic bit f_wen(input int op, input int rt, input int rd);
        if (op == 8 || op == 10) return 1'b1;                     // R4
        if (op >= 1 && op <= 3) return f_dst(op, rt, rd) != 0;
        return 1'b0;
    endfunction

    task automatic shadow_clear();
        for (int i = 0; i < 3; i++) begin
            sh_wen[i] = 1'b0;
            sh_dst[i] = '0;
        end
        sh_eop = 0;
    endtask

    // one clock of decode with the given fields; returns observed stall
    task automatic step(input int op, input int rs, input int rt, input int rd,
                        input bit zero, output bit st);
        bit taken, hz, exp_st;
        @(negedge clk);
        id_op = 4'(op); id_rs = 5'(rs); id_rt = 5'(rt); id_rd = 5'(rd);
        ex_src_zero = zero;
        #2;
        taken = (sh_eop == 5 && zero) || (sh_eop == 6 && !zero);
        hz = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (sh_wen[i] && f_re1(op) && sh_dst[i] == 5'(rs)) hz = 1'b1;
            if (sh_wen[i] && f_re2(op) && sh_dst[i] == 5'(rt)) hz = 1'b1;
        end
        exp_st = hz && !taken;
        chk(stall == exp_st, taken ? "R8 stall" : "R7 stall", int'(stall), int'(exp_st));
        chk(branch_kill == taken, "R8 kill", int'(branch_kill), int'(taken));
        st = stall;
        @(posedge clk);
        sh_wen[2] = sh_wen[1]; sh_dst[2] = sh_dst[1];
        sh_wen[1] = sh_wen[0]; sh_dst[1] = sh_dst[0];
        if (exp_st || taken) begin
            sh_wen[0] = 1'b0; sh_dst[0] = '0; sh_eop = 0;
        end else begin
            sh_wen[0] = f_wen(op, rt, rd);
            sh_dst[0] = 5'(f_dst(op, rt, rd));
            sh_eop    = op;
        end
        #2;
        chk(ex_wen == sh_wen[0], "R9 ex_wen", int'(ex_wen), int'(sh_wen[0]));
        chk(mem_wen == sh_wen[1], "R9 mem_wen", int'(mem_wen), int'(sh_wen[1]));
        chk(wb_wen == sh_wen[2], "R9 wb_wen", int'(wb_wen), int'(sh_wen[2]));
        if (sh_wen[0]) chk(ex_dst == sh_dst[0], "R3 ex_dst", int'(ex_dst), int'(sh_dst[0]));
        if (sh_wen[1]) chk(mem_dst == sh_dst[1], "R9 mem_dst", int'(mem_dst), int'(sh_dst[1]));
        if (sh_wen[2]) chk(wb_dst == sh_dst[2], "R9 wb_dst", int'(wb_dst), int'(sh_dst[2]));
    endtask

    // hold an instruction in decode until it leaves; count stall cycles
    task automatic issue(input int op, input int rs, input int rt, input int rd,
                         input bit zero, output int n);
        bit st;
        n = 0;
        for (int k = 0; k < 8; k++) begin
            step(op, rs, rt, rd, zero, st);
            if (!st) break;
            n++;
        end
    endtask

    task automatic drain();
        int n;
        for (int k = 0; k < 3; k++) issue(0, 0, 0, 0, 1'b0, n);
    endtask

    initial begin
        int n, exp_n;
        rst_n = 1'b0;
        id_op = '0; id_rs = '0; id_rt = '0; id_rd = '0; ex_src_zero = 1'b0;
        shadow_clear();
        repeat (3) @(posedge clk);
        #2;
        chk(stall == 1'b0, "R1 stall", int'(stall), 0);
        chk(!ex_wen && !mem_wen && !wb_wen, "R1 wen", int'({ex_wen, mem_wen, wb_wen}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk(!ex_wen && !mem_wen && !wb_wen && !branch_kill, "R1 after release",
            int'({ex_wen, mem_wen, wb_wen, branch_kill}), 0);

        // R10: adjacent dependent ALU pair, on rs and on rt
        issue(1, 2, 3, 1, 1'b0, n);
        issue(1, 1, 4, 5, 1'b0, n);
        chk(n == 3, "R10 rs pair", n, 3);
        drain();
        issue(1, 2, 3, 6, 1'b0, n);
        issue(1, 4, 6, 7, 1'b0, n);
        chk(n == 3, "R10 rt pair", n, 3);
        drain();

        // R10: one to three independent instructions in between
        for (int gap = 1; gap <= 3; gap++) begin
            issue(2, 0, 8, 0, 1'b0, n);
            for (int j = 0; j < gap; j++) issue(1, 20, 21, 22, 1'b0, n);
            issue(4, 8, 9, 0, 1'b0, n);
            chk(n == 3 - gap, "R10 gap", n, 3 - gap);
            drain();
        end

        // R4: ALU writing register 0 never stalls its reader
        issue(1, 2, 3, 0, 1'b0, n);
        issue(1, 0, 0, 9, 1'b0, n);
        chk(n == 0, "R4 reg0", n, 0);
        drain();

        // R3: link register written by jump-and-link, read by jump-register
        issue(8, 0, 0, 0, 1'b0, n);
        issue(9, 31, 0, 0, 1'b0, n);
        chk(n == 3, "R3 link", n, 3);
        drain();

        // R8: taken branch in execute overrides a pending memory match
        issue(1, 2, 3, 12, 1'b0, n);
        issue(5, 13, 0, 0, 1'b0, n);
        issue(1, 12, 0, 14, 1'b1, n);
        chk(n == 0, "R8 taken", n, 0);
        chk(ex_wen == 1'b0, "R8 bubble", int'(ex_wen), 0);
        drain();
        // not taken: the reader waits for memory and writeback
        issue(1, 2, 3, 12, 1'b0, n);
        issue(5, 13, 0, 0, 1'b0, n);
        issue(1, 12, 0, 14, 1'b0, n);
        chk(n == 2, "R8 not taken", n, 2);
        drain();

        // R2 R5 R6 R4: every ordered pair of codes, zero and nonzero target
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 16; c++) begin
                for (int z = 0; z < 2; z++) begin
                    int t;
                    t = (z == 0) ? 0 : 7;
                    issue(p, 3, t, t, 1'b1, n);
                    issue(c, t, t, 9, 1'b1, n);
                    exp_n = (f_wen(p, t, t) &&
                             ((f_re1(c) && f_dst(p, t, t) == t) ||
                              (f_re2(c) && f_dst(p, t, t) == t))) ? 3 : 0;
                    chk(n == exp_n, "R2 pair sweep", n, exp_n);
                    drain();
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

endmodule